// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Slave

This block lets an external processor reach a small file of 8-bit registers over a parallel bus. One set of pins serves two strobe styles, and a static two-bit mode input picks which one applies. In the separate-strobe style the host uses an active-low read strobe, an active-low write strobe and an active-high ready. In the data-strobe style the host uses a single active-low data strobe and a read/write level, and completion is shown by an active-low acknowledge. In both styles a falling edge on the address-latch pin captures a 4-bit register address, and no access can happen unless chip select is low.

Every host input is sampled into the local clock domain through a two-stage synchronizer. A control FSM turns the synchronized strobes into single-cycle load-read and commit-write pulses for a separate datapath. The datapath holds the address latch, the register file, a sticky alarm status register and an interrupt mask. Read data is driven through a separate output-enable. An active-low interrupt output reports any status bit whose mask bit is set. The local clock is expected to run at least four times faster than the host strobe rate.

Top module: `host_bus_slave`

## Requirements
- R1: After reset, dataOe is 0, intN is 1, every register reads 0, and ackOut sits at its idle level. The idle level is 0 when modeSel[0]=0 and 1 when modeSel[0]=1.
- R2: The value on addr is captured only when aleAs falls. Changing addr while aleAs stays low does not change which register the next access reaches.
- R3: When modeSel[0]=0, a read happens while csN=0, rdDsN=0 and wrRw=1, and a write happens while csN=0, wrRw=0 and rdDsN=1. In this mode wrRw is the write strobe.
- R4: When modeSel[0]=1, an access happens while csN=0 and rdDsN=0, where rdDsN is the data strobe. wrRw=1 makes the access a read and wrRw=0 makes it a write.
- R5: While csN=1, strobes cause no write, no output enable and no acknowledge.
- R6: A write changes the addressed register exactly once. The change happens when the strobe (or chip select) is seen deasserted, not while the strobe is still held.
- R7: Start counting at the first rising clock edge that samples a strobe low. The acknowledge is active after the fourth edge and not after the third. It is active-high ready when modeSel[0]=0 and active-low acknowledge when modeSel[0]=1. It returns to idle by the third edge after the strobe is released.
- R8: During a read, dataOe rises on the third edge after the strobe is sampled low. dataOut then holds the latched register's value, and dataOe stays high until the third edge after the strobe is released. dataOe is never 1 during a write or while csN=1.
- R9: Register 0 is the alarm status register. A high alarmIn bit sets the matching bit on the next clock, and writing a 1 to a bit clears it (the alarm wins if both happen together). Register 1 is the interrupt mask. Registers 2 to 15 are plain read/write storage.
- R10: intN is 0 exactly when some bit is set in both register 0 and register 1. It follows a change of either register on the next clock.
- R11: Mode 10 behaves as mode 00, and mode 11 behaves as mode 01 (the strobe style is chosen by modeSel[0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Static bus style select; bit 0 picks the data-strobe style |
| csN | input | 1 | Active-low chip select |
| aleAs | input | 1 | Address latch pin; the address is captured on its falling edge |
| rdDsN | input | 1 | Read strobe, or data strobe in data-strobe style |
| wrRw | input | 1 | Write strobe, or read/write level in data-strobe style |
| addr | input | 4 | Register address |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| dataOe | output | 1 | Output enable for dataOut |
| ackOut | output | 1 | Ready (active high) or acknowledge (active low) |
| intN | output | 1 | Active-low interrupt |
| alarmIn | input | 8 | Alarm pulses that set status bits |

## Verification
If the FSM enters the wrong state, the fault shows at the ports within four local clocks of a strobe edge. It appears as an acknowledge or output enable that turns on at the wrong moment, or one that never returns to idle. A bad address latch or a missed or doubled write commit stays hidden until the register is read back, so every random write is later checked by a read compared against a bench model. Errors in the status or mask registers show on intN one clock after the commit. The bench compares intN against the model both mid-strobe and after release.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef struct packed {
    logic loadAddr;
    logic loadRead;
    logic commitWrite;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } accState_t;

  localparam logic [1:0] MODE_SEP_ASYNC  = 2'b00;
  localparam logic [1:0] MODE_DS_ASYNC   = 2'b01;
  localparam logic [1:0] MODE_SEP_SYNC   = 2'b10;
  localparam logic [1:0] MODE_BOTH_SYNC  = 2'b11;

  localparam int STATUS_IDX = 0;
  localparam int ENABLE_IDX = 1;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RST_VAL;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/hbs_ctl.sv
module hbs_ctl import hbs_pkg::*; (
  input  logic   clk,
  input  logic   rstN,
  input  logic   motoMode,
  input  logic   aleS,
  input  logic   csNS,
  input  logic   rdDsNS,
  input  logic   wrRwS,
  input  logic   rawCsN,
  input  logic   rawWrRw,
  output dpCtl_t dpCtl,
  output logic   ackActive,
  output logic   dataOe
);
  accState_t state, stateNext;
  logic aleQ, ackQ;
  logic readReq, writeReq, readHold, writeHold;
  logic loadRead, commitWrite;

  assign readReq   = ~csNS & ~rdDsNS & wrRwS;
  assign writeReq  = ~csNS & (motoMode ? (~rdDsNS & ~wrRwS) : (rdDsNS & ~wrRwS));
  assign readHold  = ~csNS & ~rdDsNS;
  assign writeHold = ~csNS & (motoMode ? ~rdDsNS : ~wrRwS);

  always_comb begin
    stateNext   = state;
    loadRead    = 1'b0;
    commitWrite = 1'b0;
    case (state)
      ST_IDLE: begin
        if (readReq) begin
          stateNext = ST_READ;
          loadRead  = 1'b1;
        end else if (writeReq) begin
          stateNext = ST_WRITE;
        end
      end
      ST_READ: begin
        if (!readHold) stateNext = ST_IDLE;
      end
      ST_WRITE: begin
        if (!writeHold) begin
          stateNext   = ST_IDLE;
          commitWrite = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      aleQ  <= 1'b0;
      ackQ  <= 1'b0;
    end else begin
      state <= stateNext;
      aleQ  <= aleS;
      ackQ  <= (state != ST_IDLE) && (stateNext != ST_IDLE);
    end
  end

  assign dpCtl.loadAddr    = aleQ & ~aleS;
  assign dpCtl.loadRead    = loadRead;
  assign dpCtl.commitWrite = commitWrite;
  assign ackActive         = ackQ;
  assign dataOe            = (state == ST_READ) & ~rawCsN & rawWrRw;

  // R7
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) == ST_IDLE && stateNext == state) |=> ackQ);

  // R6
  commit_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.commitWrite |=> !dpCtl.commitWrite);

  // R5
  cs_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    csNS |=> (state == ST_IDLE));
endmodule

// File: rtl/hbs_dp.sv
module hbs_dp import hbs_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  input  logic [DATA_W-1:0] alarmIn,
  output logic [DATA_W-1:0] rdData,
  output logic              intN
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regQ [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regQ[i] <= '0;
      addrQ   <= '0;
      rdDataQ <= '0;
    end else begin
      if (dpCtl.loadAddr) addrQ <= addrS;
      if (dpCtl.loadRead) rdDataQ <= regQ[addrQ];
      for (int i = 0; i < DEPTH; i++) begin
        if (i == STATUS_IDX) begin
          regQ[i] <= (regQ[i] & ~((dpCtl.commitWrite && addrQ == ADDR_W'(i)) ? dataS : '0))
                     | alarmIn;
        end else if (dpCtl.commitWrite && addrQ == ADDR_W'(i)) begin
          regQ[i] <= dataS;
        end
      end
    end
  end

  assign rdData = rdDataQ;
  assign intN   = ~|(regQ[STATUS_IDX] & regQ[ENABLE_IDX]);

  // R9
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIn != '0) |=> ((regQ[STATUS_IDX] & $past(alarmIn)) == $past(alarmIn)));
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              csN,
  input  logic              aleAs,
  input  logic              rdDsN,
  input  logic              wrRw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ackOut,
  output logic              intN,
  input  logic [DATA_W-1:0] alarmIn
);
  import hbs_pkg::*;

  localparam int BUS_W = ADDR_W + DATA_W;

  logic              motoMode;
  logic [3:0]        pinS;
  logic [BUS_W-1:0]  busS;
  logic              ackActive;
  dpCtl_t            dpCtl;

  always_comb begin
    case (modeSel)
      MODE_SEP_ASYNC, MODE_SEP_SYNC: motoMode = 1'b0;
      MODE_DS_ASYNC, MODE_BOTH_SYNC: motoMode = 1'b1;
      default:                       motoMode = 1'b0;
    endcase
  end

  hbs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) i_pinSync (
    .clk(clk), .rstN(rstN),
    .din({aleAs, csN, rdDsN, wrRw}),
    .dout(pinS)
  );

  hbs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_busSync (
    .clk(clk), .rstN(rstN),
    .din({addr, dataIn}),
    .dout(busS)
  );

  hbs_ctl i_ctl (
    .clk(clk), .rstN(rstN), .motoMode(motoMode),
    .aleS(pinS[3]), .csNS(pinS[2]), .rdDsNS(pinS[1]), .wrRwS(pinS[0]),
    .rawCsN(csN), .rawWrRw(wrRw),
    .dpCtl(dpCtl), .ackActive(ackActive), .dataOe(dataOe)
  );

  hbs_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .addrS(busS[BUS_W-1:DATA_W]), .dataS(busS[DATA_W-1:0]),
    .alarmIn(alarmIn), .rdData(dataOut), .intN(intN)
  );

  assign ackOut = motoMode ? ~ackActive : ackActive;
endmodule

// File: tb/test_host_bus_slave.sv
module test_host_bus_slave;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN;
  logic [1:0] modeSel;
  logic       csN, aleAs, rdDsN, wrRw;
  logic [3:0] addr;
  logic [7:0] dataIn, dataOut, alarmIn;
  logic       dataOe, ackOut, intN;

  int checks = 0;
  int failures = 0;
  logic [7:0] modelMem [16];

  host_bus_slave i_host_bus_slave (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .aleAs(aleAs),
    .rdDsN(rdDsN), .wrRw(wrRw), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .ackOut(ackOut), .intN(intN),
    .alarmIn(alarmIn)
  );

  function automatic logic ackIdle(logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic expIntN();
    return ~|(modelMem[0] & modelMem[1]);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latchAddr(logic [3:0] a);
    addr = a; aleAs = 1'b1;
    tick(3);
    aleAs = 1'b0;
    tick(4);
  endtask

  task automatic hostWrite(logic [3:0] a, logic [7:0] d, bit selected);
    latchAddr(a);
    dataIn = d;
    csN = !selected;
    wrRw = 1'b0;
    if (modeSel[0]) rdDsN = 1'b0;
    tick(5);
    if (selected) begin
      chk(ackOut == !ackIdle(modeSel), "R7 write ack", ackOut, !ackIdle(modeSel));
      chk(dataOe == 1'b0, "R8 oe during write", dataOe, 0);
      chk(intN == expIntN(), "R6 no commit before release", intN, expIntN());
    end else begin
      chk(ackOut == ackIdle(modeSel) && !dataOe, "R5 cs high blocks",
          {ackOut, dataOe}, {ackIdle(modeSel), 1'b0});
    end
    if (modeSel[0]) rdDsN = 1'b1; else wrRw = 1'b1;
    tick(4);
    chk(ackOut == ackIdle(modeSel), "R7 ack idle after write", ackOut, ackIdle(modeSel));
    wrRw = 1'b1; csN = 1'b1;
    if (selected) begin
      if (a == 4'd0) modelMem[0] = modelMem[0] & ~d;
      else modelMem[a] = d;
    end
    chk(intN == expIntN(), "R10 intN after write", intN, expIntN());
    tick(2);
  endtask

  task automatic hostRead(logic [3:0] a, string tag);
    latchAddr(a);
    csN = 1'b0; wrRw = 1'b1; rdDsN = 1'b0;
    tick(5);
    chk(dataOe == 1'b1, "R8 oe during read", dataOe, 1);
    chk(dataOut == modelMem[a], tag, dataOut, modelMem[a]);
    chk(ackOut == !ackIdle(modeSel), "R7 read ack", ackOut, !ackIdle(modeSel));
    rdDsN = 1'b1;
    tick(4);
    chk(!dataOe && ackOut == ackIdle(modeSel), "R8 oe off after read",
        {dataOe, ackOut}, {1'b0, ackIdle(modeSel)});
    csN = 1'b1;
    tick(2);
  endtask

  task automatic pulseAlarm(logic [7:0] a);
    alarmIn = a;
    tick(1);
    alarmIn = '0;
    modelMem[0] = modelMem[0] | a;
    chk(intN == expIntN(), "R10 intN after alarm", intN, expIntN());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) modelMem[i] = '0;
    void'($urandom(32'd4711));
    rstN = 1'b0; modeSel = 2'b00; csN = 1'b1; aleAs = 1'b0; rdDsN = 1'b1;
    wrRw = 1'b1; addr = '0; dataIn = '0; alarmIn = '0;
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1 reset state
    chk(dataOe == 1'b0, "R1 oe after reset", dataOe, 0);
    chk(intN == 1'b1, "R1 intN after reset", intN, 1);
    chk(ackOut == 1'b0, "R1 ready idle mode 00", ackOut, 0);
    modeSel = 2'b01; tick(1);
    chk(ackOut == 1'b1, "R1 ack idle mode 01", ackOut, 1);
    modeSel = 2'b00; tick(1);
    hostRead(4'd12, "R1 register zero after reset");

    // R7 / R8 exact latency on a separate-strobe read
    latchAddr(4'd3);
    csN = 1'b0; rdDsN = 1'b0;
    tick(3);
    chk(dataOe == 1'b1, "R8 oe on third edge", dataOe, 1);
    chk(ackOut == 1'b0, "R7 ready not yet on third edge", ackOut, 0);
    tick(1);
    chk(ackOut == 1'b1, "R7 ready on fourth edge", ackOut, 1);
    rdDsN = 1'b1;
    tick(2);
    chk(dataOe == 1'b1 && ackOut == 1'b1, "R8 oe held until release seen",
        {dataOe, ackOut}, 2'b11);
    tick(1);
    chk(dataOe == 1'b0 && ackOut == 1'b0, "R7 idle on third edge after release",
        {dataOe, ackOut}, 2'b00);
    csN = 1'b1; tick(2);

    // R3 separate-strobe style
    hostWrite(4'd5, 8'hA5, 1'b1);
    hostRead(4'd5, "R3 read back");
    // R4 data-strobe style
    modeSel = 2'b01; tick(1);
    hostWrite(4'd6, 8'h3C, 1'b1);
    hostRead(4'd6, "R4 read back");
    hostRead(4'd5, "R4 read older value");
    // R11 mode aliases
    modeSel = 2'b10; tick(1);
    hostWrite(4'd7, 8'h5A, 1'b1);
    hostRead(4'd7, "R11 mode 10");
    modeSel = 2'b11; tick(1);
    hostWrite(4'd8, 8'hC3, 1'b1);
    hostRead(4'd8, "R11 mode 11");
    // R5 chip select high blocks writes
    hostWrite(4'd8, 8'hFF, 1'b0);
    hostRead(4'd8, "R5 no write with cs high");
    modeSel = 2'b00; tick(1);
    hostWrite(4'd5, 8'h00, 1'b0);
    hostRead(4'd5, "R5 no write with cs high");

    // R2 address taken only at the latch edge
    hostWrite(4'd9, 8'h99, 1'b1);
    hostWrite(4'd10, 8'h10, 1'b1);
    latchAddr(4'd9);
    addr = 4'd10;
    tick(3);
    csN = 1'b0; rdDsN = 1'b0;
    tick(5);
    chk(dataOut == 8'h99, "R2 latched address used", dataOut, 8'h99);
    rdDsN = 1'b1; tick(4); csN = 1'b1; tick(2);

    // R9 / R10 status and mask
    pulseAlarm(8'h01);
    chk(intN == 1'b1, "R10 masked alarm", intN, 1);
    hostRead(4'd0, "R9 status sticky");
    hostWrite(4'd1, 8'h01, 1'b1);
    chk(intN == 1'b0, "R10 enabled alarm", intN, 0);
    hostWrite(4'd0, 8'h01, 1'b1);
    chk(intN == 1'b1, "R9 write one clears", intN, 1);
    hostRead(4'd0, "R9 status cleared");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      modeSel = 2'($urandom_range(0, 3));
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      tick(1);
      if ($urandom_range(0, 3) == 0) pulseAlarm(8'($urandom));
      if ($urandom_range(0, 1) == 1) hostWrite(a, d, ($urandom_range(0, 5) != 0));
      else hostRead(a, "R9 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule